// File: doc/BRIEF.md
# Phase Alarm and Switch Qualification Guard

This block sits on the decision path of a clock-channel phase monitor. Each clock cycle it may receive one phase decision sample (an unsigned magnitude), together with a flag marking a burst or outlier and an input that is high while a clock-path switch or other known transient is under way. It turns these into a two-level alarm, a qualify flag, and a grant for requested path switches.

Two limits are formed from a baseline and a spread value, each scaled by its own programmable multiplier. A higher limit is used to detect violations and a lower limit is used to clear alarms and to define the in-window region. An alarm needs a run of consecutive violating samples before it is raised. A hard alarm follows when the soft alarm has lasted a second, longer run of samples. A blanking timer hides violations during a switch and for a programmable time after it. The qualify flag needs a stable run of clean in-window samples before it rises. It falls without delay, in the same cycle as any out-of-window sample or burst.

Top module: `phase_qual_guard`

## Requirements
- R1: The high limit is `baseline + k_high*spread` and the low limit is `baseline + k_low*spread`, both computed without overflow. A sample violates only when the metric is strictly greater than the high limit. A sample is in-window only when the metric is strictly less than the low limit.
- R2: `persist_cnt` counts consecutive violating valid samples. Any valid sample that does not violate resets it to 0. On the `persist_n`-th consecutive violation, the soft alarm sets and the count returns to 0.
- R3: Once set, the soft alarm stays high until a valid sample falls below the low limit. Samples between the two limits leave it unchanged.
- R4: While the soft alarm is high, each valid sample that is not below the low limit is counted. On the `hard_n`-th such sample, `hard_alarm` rises. It clears together with the soft alarm.
- R5: `blank_active` is high while `switching` is high and for `blank_len` clock cycles after `switching` falls. While it is high, violations are ignored and the violation count is held at 0.
- R6: `qualify` rises only after `persist_n` consecutive valid samples that are in-window and burst-free, counted outside blanking. Cycles with no valid sample and no burst neither add to nor break the run.
- R7: `qualify` is low in the same cycle as a valid out-of-window sample, during any cycle with `burst_flag` high (with or without a valid sample), and during blanking. Any of these also restarts the stable run.
- R8: `switch_grant` equals `switch_req` AND `qualify` AND NOT `hard_alarm`.
- R9: `hyst_state` encodes the alarm state: 2'b00 clear, 2'b01 counting violations, 2'b10 soft alarm, 2'b11 hard alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A decision sample is present this cycle |
| metric | input | MW | Unsigned phase decision magnitude |
| burst_flag | input | 1 | Burst or outlier flagged |
| switching | input | 1 | Switch or known transient in progress |
| baseline | input | MW | Baseline term of both limits |
| spread | input | MW | Spread term of both limits |
| k_high | input | KW | Multiplier for the high limit |
| k_low | input | KW | Multiplier for the low limit |
| persist_n | input | CW | Consecutive-sample count for alarm and qualify (at least 1) |
| hard_n | input | HW | Soft-alarm sample count before escalation (at least 1) |
| blank_len | input | BW | Blanking cycles after switching falls |
| switch_req | input | 1 | Request to change clock path |
| soft_alarm | output | 1 | Attention-level alarm |
| hard_alarm | output | 1 | Blocking alarm |
| qualify | output | 1 | Channel fit for switching |
| switch_grant | output | 1 | Switch request accepted |
| persist_cnt | output | CW | Current consecutive-violation count |
| hyst_state | output | 2 | Alarm state code |
| blank_active | output | 1 | Blanking in force |

## Verification
The bench builds the block with MW=12, KW=4, CW=4, HW=4 and BW=4. It programs limits of 150 and 120, a persistence of 3, an escalation count of 4 and a blanking time of 3. With these values the whole path from a clean signal through pending, soft, hard and back to clear fits into about thirty samples. The blanking window and its first unblanked violation can also be observed one sample at a time. Samples exactly on each limit show the strict comparisons. Sampling qualify before the clock edge shows that it drops within the same cycle.

// File: rtl/phase_qual_pkg.sv
package phase_qual_pkg;

    typedef enum logic [1:0] {
        AL_CLEAR = 2'b00,
        AL_PEND  = 2'b01,
        AL_SOFT  = 2'b10,
        AL_HARD  = 2'b11
    } alarm_st_e;

    typedef struct packed {
        logic valid;
        logic above_hi;
        logic below_lo;
    } sample_cls_t;

endpackage

// File: rtl/qual_thresh.sv
module qual_thresh
    import phase_qual_pkg::*;
#(
    parameter int MW = 16,
    parameter int KW = 4
) (
    input  logic          sample_valid,
    input  logic [MW-1:0] metric,
    input  logic [MW-1:0] baseline,
    input  logic [MW-1:0] spread,
    input  logic [KW-1:0] k_high,
    input  logic [KW-1:0] k_low,
    output sample_cls_t   cls
);
    localparam int LW = MW + KW + 1;

    logic [LW-1:0] lim_hi;
    logic [LW-1:0] lim_lo;
    logic [LW-1:0] m_ext;

    always_comb begin
        m_ext        = LW'(metric);
        lim_hi       = LW'(baseline) + LW'(k_high) * LW'(spread);
        lim_lo       = LW'(baseline) + LW'(k_low) * LW'(spread);
        cls.valid    = sample_valid;
        cls.above_hi = m_ext > lim_hi;
        cls.below_lo = m_ext < lim_lo;
    end
endmodule

// File: rtl/qual_blank.sv
module qual_blank #(
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          switching,
    input  logic [BW-1:0] blank_len,
    output logic          blank_active
);
    logic [BW-1:0] blank_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            blank_cnt <= '0;
        else if (switching)
            blank_cnt <= blank_len;
        else if (blank_cnt != '0)
            blank_cnt <= blank_cnt - 1'b1;
    end

    assign blank_active = switching || (blank_cnt != '0);
endmodule

// File: rtl/qual_stable.sv
module qual_stable #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_valid,
    input  logic          in_window,
    input  logic          burst_flag,
    input  logic          blank_active,
    input  logic [CW-1:0] persist_n,
    output logic          qualify
);
    logic [CW-1:0] stable_cnt;
    logic          breaks_run;
    logic          qual_base;

    assign breaks_run = burst_flag || blank_active || (sample_valid && !in_window);

    always_ff @(posedge clk) begin
        if (rst)
            stable_cnt <= '0;
        else if (breaks_run)
            stable_cnt <= '0;
        else if (sample_valid && (stable_cnt < persist_n))
            stable_cnt <= stable_cnt + 1'b1;
    end

    assign qual_base = stable_cnt >= persist_n;
    assign qualify   = qual_base && !breaks_run;
endmodule

// File: rtl/qual_alarm_fsm.sv
module qual_alarm_fsm
    import phase_qual_pkg::*;
#(
    parameter int CW = 8,
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  sample_cls_t   cls,
    input  logic          blank_active,
    input  logic [CW-1:0] persist_n,
    input  logic [HW-1:0] hard_n,
    output alarm_st_e     state,
    output logic [CW-1:0] viol_cnt
);
    alarm_st_e     st_nx;
    logic [CW-1:0] vc_nx;
    logic [HW-1:0] hard_cnt;
    logic [HW-1:0] hc_nx;
    logic          viol;
    logic          viol_done;
    logic          hard_done;

    assign viol      = cls.valid && cls.above_hi && !blank_active;
    assign viol_done = ({1'b0, viol_cnt} + 1'b1) >= {1'b0, persist_n};
    assign hard_done = ({1'b0, hard_cnt} + 1'b1) >= {1'b0, hard_n};

    always_comb begin
        st_nx = state;
        vc_nx = viol_cnt;
        hc_nx = hard_cnt;
        unique case (state)
            AL_CLEAR: begin
                if (viol) begin
                    if (viol_done) begin
                        st_nx = AL_SOFT;
                        vc_nx = '0;
                        hc_nx = '0;
                    end else begin
                        st_nx = AL_PEND;
                        vc_nx = viol_cnt + 1'b1;
                    end
                end
            end
            AL_PEND: begin
                if (blank_active) begin
                    st_nx = AL_CLEAR;
                    vc_nx = '0;
                end else if (cls.valid) begin
                    if (cls.above_hi) begin
                        if (viol_done) begin
                            st_nx = AL_SOFT;
                            vc_nx = '0;
                            hc_nx = '0;
                        end else begin
                            vc_nx = viol_cnt + 1'b1;
                        end
                    end else begin
                        st_nx = AL_CLEAR;
                        vc_nx = '0;
                    end
                end
            end
            AL_SOFT: begin
                if (cls.valid) begin
                    if (cls.below_lo) begin
                        st_nx = AL_CLEAR;
                        hc_nx = '0;
                    end else if (hard_done) begin
                        st_nx = AL_HARD;
                        hc_nx = '0;
                    end else begin
                        hc_nx = hard_cnt + 1'b1;
                    end
                end
            end
            AL_HARD: begin
                if (cls.valid && cls.below_lo)
                    st_nx = AL_CLEAR;
            end
            default: st_nx = AL_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= AL_CLEAR;
            viol_cnt <= '0;
            hard_cnt <= '0;
        end else begin
            state    <= st_nx;
            viol_cnt <= vc_nx;
            hard_cnt <= hc_nx;
        end
    end
endmodule

// File: rtl/phase_qual_guard.sv
module phase_qual_guard
    import phase_qual_pkg::*;
#(
    parameter int MW = 16,
    parameter int KW = 4,
    parameter int CW = 8,
    parameter int HW = 12,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_valid,
    input  logic [MW-1:0] metric,
    input  logic          burst_flag,
    input  logic          switching,
    input  logic [MW-1:0] baseline,
    input  logic [MW-1:0] spread,
    input  logic [KW-1:0] k_high,
    input  logic [KW-1:0] k_low,
    input  logic [CW-1:0] persist_n,
    input  logic [HW-1:0] hard_n,
    input  logic [BW-1:0] blank_len,
    input  logic          switch_req,
    output logic          soft_alarm,
    output logic          hard_alarm,
    output logic          qualify,
    output logic          switch_grant,
    output logic [CW-1:0] persist_cnt,
    output logic [1:0]    hyst_state,
    output logic          blank_active
);
    sample_cls_t cls;
    alarm_st_e   al_state;
    logic        qual_int;

    qual_thresh #(.MW(MW), .KW(KW)) u_thresh (
        .sample_valid (sample_valid),
        .metric       (metric),
        .baseline     (baseline),
        .spread       (spread),
        .k_high       (k_high),
        .k_low        (k_low),
        .cls          (cls)
    );

    qual_blank #(.BW(BW)) u_blank (
        .clk          (clk),
        .rst          (rst),
        .switching    (switching),
        .blank_len    (blank_len),
        .blank_active (blank_active)
    );

    qual_stable #(.CW(CW)) u_stable (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (cls.valid),
        .in_window    (cls.below_lo),
        .burst_flag   (burst_flag),
        .blank_active (blank_active),
        .persist_n    (persist_n),
        .qualify      (qual_int)
    );

    qual_alarm_fsm #(.CW(CW), .HW(HW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cls          (cls),
        .blank_active (blank_active),
        .persist_n    (persist_n),
        .hard_n       (hard_n),
        .state        (al_state),
        .viol_cnt     (persist_cnt)
    );

    assign soft_alarm   = (al_state == AL_SOFT) || (al_state == AL_HARD);
    assign hard_alarm   = (al_state == AL_HARD);
    assign hyst_state   = al_state;
    assign qualify      = qual_int;
    assign switch_grant = switch_req && qual_int && !hard_alarm;
endmodule

// File: rtl/qual_guard_chk.sv
module qual_guard_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          burst_flag,
    input logic          switch_req,
    input logic [CW-1:0] persist_n,
    input logic          soft_alarm,
    input logic          hard_alarm,
    input logic          qualify,
    input logic          switch_grant,
    input logic [CW-1:0] persist_cnt,
    input logic [1:0]    hyst_state,
    input logic          blank_active
);
    // R2: soft alarm rises only after a full run of violations
    a_r2_soft_after_run: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_alarm) && !$past(soft_alarm) |->
            (({1'b0, $past(persist_cnt)} + 1'b1) >= {1'b0, $past(persist_n)}));

    // R4: hard alarm always sits on top of a soft alarm
    a_r4_hard_implies_soft: assert property (@(posedge clk) disable iff (rst)
        hard_alarm |-> soft_alarm);

    // R5: blanking holds the violation count at zero and sets no new alarm
    a_r5_blank_no_count: assert property (@(posedge clk) disable iff (rst)
        blank_active |=> persist_cnt == '0);
    a_r5_blank_no_raise: assert property (@(posedge clk) disable iff (rst)
        blank_active && !soft_alarm |=> !soft_alarm);

    // R7: qualify is low during bursts and blanking
    a_r7_burst_drops: assert property (@(posedge clk) disable iff (rst)
        burst_flag |-> !qualify);
    a_r7_blank_drops: assert property (@(posedge clk) disable iff (rst)
        blank_active |-> !qualify);

    // R8: a grant needs a request, qualify and no hard alarm
    a_r8_grant_guard: assert property (@(posedge clk) disable iff (rst)
        switch_grant |-> switch_req && qualify && !hard_alarm);

    // R9: a nonzero violation count only in the counting state
    a_r9_count_state: assert property (@(posedge clk) disable iff (rst)
        (persist_cnt != '0) |-> hyst_state == 2'b01);
endmodule

bind phase_qual_guard qual_guard_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .burst_flag   (burst_flag),
    .switch_req   (switch_req),
    .persist_n    (persist_n),
    .soft_alarm   (soft_alarm),
    .hard_alarm   (hard_alarm),
    .qualify      (qualify),
    .switch_grant (switch_grant),
    .persist_cnt  (persist_cnt),
    .hyst_state   (hyst_state),
    .blank_active (blank_active)
);

// File: tb/sim_phase_qual_guard.sv
`timescale 1ns/1ps
module sim_phase_qual_guard;
    localparam int MW = 12;
    localparam int KW = 4;
    localparam int CW = 4;
    localparam int HW = 4;
    localparam int BW = 4;
    localparam int NV = 30;

    // vector: valid, burst, sw, metric[15:0], soft, hard, qual, blank, pcnt[7:0]
    function automatic logic [30:0] mk(input int v, input int b, input int s, input int m,
                                       input int es, input int eh, input int eq,
                                       input int eb, input int ep);
        return {v[0], b[0], s[0], m[15:0], es[0], eh[0], eq[0], eb[0], ep[7:0]};
    endfunction

    localparam logic [30:0] TBL [NV] = '{
        mk(1,0,0,100, 0,0,0,0,0), mk(1,0,0,110, 0,0,0,0,0), mk(1,0,0,105, 0,0,1,0,0),
        mk(1,0,0,130, 0,0,0,0,0), mk(1,0,0,100, 0,0,0,0,0), mk(1,0,0,160, 0,0,0,0,1),
        mk(1,0,0,170, 0,0,0,0,2), mk(1,0,0,140, 0,0,0,0,0), mk(1,0,0,160, 0,0,0,0,1),
        mk(1,0,0,160, 0,0,0,0,2), mk(1,0,0,160, 1,0,0,0,0), mk(1,0,0,130, 1,0,0,0,0),
        mk(1,0,0,125, 1,0,0,0,0), mk(1,0,0,135, 1,0,0,0,0), mk(1,0,0,130, 1,1,0,0,0),
        mk(1,0,0,140, 1,1,0,0,0), mk(1,0,0,115, 0,0,0,0,0), mk(1,0,0,110, 0,0,0,0,0),
        mk(1,1,0,110, 0,0,0,0,0), mk(1,0,0,100, 0,0,0,0,0), mk(1,0,0,100, 0,0,0,0,0),
        mk(1,0,0,100, 0,0,1,0,0), mk(0,0,0,100, 0,0,1,0,0), mk(0,1,0,100, 0,0,0,0,0),
        mk(1,0,1,200, 0,0,0,1,0), mk(1,0,0,200, 0,0,0,1,0), mk(1,0,0,200, 0,0,0,1,0),
        mk(1,0,0,200, 0,0,0,0,0), mk(1,0,0,200, 0,0,0,0,1), mk(1,0,0,100, 0,0,0,0,0)
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          sample_valid;
    logic [MW-1:0] metric;
    logic          burst_flag;
    logic          switching;
    logic [MW-1:0] baseline;
    logic [MW-1:0] spread;
    logic [KW-1:0] k_high;
    logic [KW-1:0] k_low;
    logic [CW-1:0] persist_n;
    logic [HW-1:0] hard_n;
    logic [BW-1:0] blank_len;
    logic          switch_req;
    logic          soft_alarm;
    logic          hard_alarm;
    logic          qualify;
    logic          switch_grant;
    logic [CW-1:0] persist_cnt;
    logic [1:0]    hyst_state;
    logic          blank_active;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    phase_qual_guard #(.MW(MW), .KW(KW), .CW(CW), .HW(HW), .BW(BW)) u0 (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .metric(metric),
        .burst_flag(burst_flag), .switching(switching), .baseline(baseline),
        .spread(spread), .k_high(k_high), .k_low(k_low), .persist_n(persist_n),
        .hard_n(hard_n), .blank_len(blank_len), .switch_req(switch_req),
        .soft_alarm(soft_alarm), .hard_alarm(hard_alarm), .qualify(qualify),
        .switch_grant(switch_grant), .persist_cnt(persist_cnt),
        .hyst_state(hyst_state), .blank_active(blank_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic b, input logic s, input int m);
        sample_valid = v;
        burst_flag   = b;
        switching    = s;
        metric       = MW'(m);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 0);
        baseline = 100; spread = 10; k_high = 5; k_low = 2;   // limits 150 / 120
        persist_n = 3; hard_n = 4; blank_len = 3; switch_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        // reset state
        chk("R2 reset persist_cnt", int'(persist_cnt), 0);
        chk("R3 reset soft", int'(soft_alarm), 0);
        chk("R4 reset hard", int'(hard_alarm), 0);
        chk("R6 reset qualify", int'(qualify), 0);
        chk("R9 reset state", int'(hyst_state), 0);
        chk("R5 reset blank", int'(blank_active), 0);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = TBL[i];
            drive(v[30], v[29], v[28], int'(v[27:12]));
            tick();
            chk($sformatf("R3 vec%0d soft", i), int'(soft_alarm), int'(v[11]));
            chk($sformatf("R4 vec%0d hard", i), int'(hard_alarm), int'(v[10]));
            chk($sformatf("R6 vec%0d qualify", i), int'(qualify), int'(v[9]));
            chk($sformatf("R5 vec%0d blank", i), int'(blank_active), int'(v[8]));
            chk($sformatf("R2 vec%0d persist_cnt", i), int'(persist_cnt), int'(v[7:0]));
        end

        // R1: metric equal to the high limit is no violation
        drive(1'b1, 1'b0, 1'b0, 150);
        tick();
        chk("R1 at high limit persist_cnt", int'(persist_cnt), 0);
        chk("R1 at high limit state", int'(hyst_state), 0);

        // R6 then R7: qualify rises, then drops before the edge on limit-equal sample
        for (int j = 0; j < 3; j++) begin
            drive(1'b1, 1'b0, 1'b0, 119);
            tick();
        end
        chk("R6 three in-window samples", int'(qualify), 1);
        drive(1'b1, 1'b0, 1'b0, 120);
        #1;
        chk("R7 same-cycle drop at low limit", int'(qualify), 0);
        tick();
        chk("R7 after out-of-window sample", int'(qualify), 0);

        // R8: grant gating
        for (int j = 0; j < 3; j++) begin
            drive(1'b1, 1'b0, 1'b0, 100);
            tick();
        end
        switch_req = 1'b1;
        #1;
        chk("R8 grant when qualified", int'(switch_grant), 1);
        burst_flag = 1'b1;
        #1;
        chk("R8 no grant during burst", int'(switch_grant), 0);
        chk("R7 qualify low during burst", int'(qualify), 0);
        burst_flag = 1'b0;
        switch_req = 1'b0;
        tick();

        // R1: reprogrammed multiplier moves the high limit to 130
        k_high = 3;
        drive(1'b1, 1'b0, 1'b0, 140);
        tick();
        chk("R1 new high limit counts", int'(persist_cnt), 1);
        chk("R9 counting state", int'(hyst_state), 1);
        drive(1'b1, 1'b0, 1'b0, 140);
        tick();
        drive(1'b1, 1'b0, 1'b0, 140);
        tick();
        chk("R9 soft state", int'(hyst_state), 2);
        for (int j = 0; j < 4; j++) begin
            drive(1'b1, 1'b0, 1'b0, 125);
            tick();
        end
        chk("R9 hard state", int'(hyst_state), 3);
        switch_req = 1'b1;
        #1;
        chk("R8 no grant under hard alarm", int'(switch_grant), 0);
        switch_req = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 100);
        tick();
        chk("R4 hard clears below low limit", int'(hard_alarm), 0);
        chk("R3 soft clears below low limit", int'(soft_alarm), 0);
        drive(1'b0, 1'b0, 1'b0, 0);
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule